// File: doc/BRIEF.md
# Prefetch Burst Gearbox

This block sits between a wide core-side data word and a double-data-rate pin-side beat stream. A write burst takes one core word of eight beats in a single clock cycle. It then plays the beats out two per clock, as a rising-edge half and a falling-edge half. A read burst collects beat pairs from the pins and hands one assembled core word to the core side, marked by a one-cycle valid pulse.

A start pulse launches each burst. The start pulse carries a direction and a chop flag. When chop is set, only four beats move instead of eight. A strobe-enable output is high for the clocks that carry beats, so the surrounding pad logic knows when to drive or capture. A new burst can be launched in the final beat-pair clock of the current one. This gives a gapless stream of bursts.

Top module: `burst_gearbox`

## Requirements
- R1: After synchronous reset, `strobe_en_o` and `rd_valid_o` are 0, and `dq_rise_o`, `dq_fall_o` and `rd_word_o` are all zero.
- R2: A full write started at clock edge T drives beat pair k (k = 0..3) during the cycle after edge T+k. `dq_rise_o` carries word bits [2kN+N-1:2kN] and `dq_fall_o` carries bits [2kN+2N-1:2kN+N], so the lowest slice goes out first.
- R3: `strobe_en_o` is high for exactly the beat-carrying cycles. That is four consecutive cycles for a full burst and two for a chopped burst, starting the cycle after the accepting edge.
- R4: A chopped write (`chop_i`=1) sends only beat pairs 0 and 1, which are word bits [4N-1:0]. The upper half of the word is never driven.
- R5: In a full read, the pair sampled at the end of strobe cycle k (`rd_rise_i`, `rd_fall_i`) lands in `rd_word_o` bits [2kN+N-1:2kN] and [2kN+2N-1:2kN+N]. The word appears with `rd_valid_o` in the cycle right after the last strobe cycle.
- R6: A chopped read captures two pairs into bits [4N-1:0] and presents the upper half of `rd_word_o` as zero.
- R7: `rd_valid_o` is a one-cycle pulse, raised only at the end of read bursts and never for writes.
- R8: A start seen while a burst is in flight is ignored, except in the burst's last strobe cycle. There it is accepted, and the next burst's strobe cycles follow with no gap.
- R9: `dq_rise_o` and `dq_fall_o` are zero whenever no write beat is being driven, including during read bursts.
- R10: `dir_i`, `chop_i` and `wr_word_i` are sampled only at an accepting edge. Changes to them during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst launch pulse |
| dir_i | input | 1 | 0 = write, 1 = read |
| chop_i | input | 1 | 1 = four-beat burst |
| wr_word_i | input | BEAT_W*BEATS | Core word to serialize |
| rd_rise_i | input | BEAT_W | Rising-edge read beat |
| rd_fall_i | input | BEAT_W | Falling-edge read beat |
| dq_rise_o | output | BEAT_W | Rising-edge write beat |
| dq_fall_o | output | BEAT_W | Falling-edge write beat |
| strobe_en_o | output | 1 | High during beat-carrying cycles |
| rd_word_o | output | BEAT_W*BEATS | Assembled read word |
| rd_valid_o | output | 1 | One-cycle read word valid |

## Verification
The valid pulse that closes a read burst and the first beat pair of a following burst can fall in the same cycle. This happens when a new start is issued during the read's final strobe cycle. The bench provokes it by running a full read and launching a chopped write on the last pair. In that one cycle it checks three things together: the assembled read word with its valid pulse, a still-high strobe, and the write's lowest beat pair on the data outputs.

// File: rtl/gearbox_pkg.sv
package gearbox_pkg;

    localparam int DEF_BEAT_W = 8;
    localparam int DEF_BEATS  = 8;

    typedef enum logic {
        XF_WRITE = 1'b0,
        XF_READ  = 1'b1
    } xfer_dir_e;

    // State of the burst currently in flight
    typedef struct packed {
        logic active;
        logic rd;
        logic chop;
    } burst_ctx_t;

    // Number of beat-pair clocks a burst occupies
    function automatic int burst_pairs(input logic chop, input int pairs);
        return chop ? (pairs / 2) : pairs;
    endfunction

endpackage

// File: rtl/gb_ctrl.sv
module gb_ctrl
    import gearbox_pkg::*;
#(
    parameter int PAIRS  = 4,
    parameter int SLOT_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic              chop_i,
    output burst_ctx_t        ctx_o,
    output logic              last_o,
    output logic              accept_o,
    output logic [SLOT_W-1:0] slot_o
);

    burst_ctx_t        ctx;
    logic [CNT_W-1:0]  cnt_left;
    logic [SLOT_W-1:0] slot;

    assign last_o   = ctx.active && (cnt_left == CNT_W'(1));
    assign accept_o = start_i && (!ctx.active || last_o);
    assign ctx_o    = ctx;
    assign slot_o   = slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx      <= '0;
            cnt_left <= '0;
            slot     <= '0;
        end else if (accept_o) begin
            ctx.active <= 1'b1;
            ctx.rd     <= (xfer_dir_e'(dir_i) == XF_READ);
            ctx.chop   <= chop_i;
            cnt_left   <= CNT_W'(burst_pairs(chop_i, PAIRS));
            slot       <= '0;
        end else if (ctx.active) begin
            cnt_left <= cnt_left - CNT_W'(1);
            slot     <= slot + SLOT_W'(1);
            if (last_o) ctx.active <= 1'b0;
        end
    end

    // R8: a non-final burst cycle always advances by one pair, start or not
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (ctx.active && !last_o) |=> (ctx.active && cnt_left == $past(cnt_left) - CNT_W'(1)));

    // R3: remaining pair count stays within the burst's length
    p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ctx.active |-> (cnt_left != '0 &&
                        int'(cnt_left) <= burst_pairs(ctx.chop, PAIRS)));

    // R3: an accepted start opens a strobe window next cycle
    p_accept_opens_r3: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> ctx.active);

endmodule

// File: rtl/gb_tx.sv
module gb_tx
    import gearbox_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  burst_ctx_t        ctx_i,
    output logic [BEAT_W-1:0] rise_o,
    output logic [BEAT_W-1:0] fall_o
);

    localparam int PAIR_W = 2 * BEAT_W;

    logic [WORD_W-1:0] shreg;
    logic              driving;

    assign driving = ctx_i.active && !ctx_i.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load_i) begin
            shreg <= word_i;
        end else if (driving) begin
            shreg <= shreg >> PAIR_W;
        end
    end

    assign rise_o = driving ? shreg[BEAT_W-1:0]      : '0;
    assign fall_o = driving ? shreg[PAIR_W-1:BEAT_W] : '0;

endmodule

// File: rtl/gb_rx.sv
module gb_rx
    import gearbox_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int PAIRS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  burst_ctx_t                ctx_i,
    input  logic                      last_i,
    input  logic [SLOT_W-1:0]         slot_i,
    input  logic [BEAT_W-1:0]         rise_i,
    input  logic [BEAT_W-1:0]         fall_i,
    output logic [2*BEAT_W*PAIRS-1:0] word_o,
    output logic                      valid_o
);

    localparam int PAIR_W = 2 * BEAT_W;
    localparam int WORD_W = PAIR_W * PAIRS;
    localparam int HALF   = PAIRS / 2;

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic              capturing;

    assign capturing = ctx_i.active && ctx_i.rd;

    for (genvar i = 0; i < PAIRS; i++) begin : g_slot
        always_comb begin
            if (ctx_i.chop && (i >= HALF))
                merged[i*PAIR_W +: PAIR_W] = '0;
            else if (slot_i == SLOT_W'(i))
                merged[i*PAIR_W +: PAIR_W] = {fall_i, rise_i};
            else
                merged[i*PAIR_W +: PAIR_W] = acc[i*PAIR_W +: PAIR_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (capturing) begin
                acc <= merged;
                if (last_i) begin
                    word_o  <= merged;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    // R7: the valid pulse lasts a single cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: a chopped read delivers a zero upper half
    p_chop_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(ctx_i.chop)) |-> (word_o[WORD_W-1:WORD_W/2] == '0));

endmodule

// File: rtl/burst_gearbox.sv
module burst_gearbox
    import gearbox_pkg::*;
#(
    parameter int BEAT_W = DEF_BEAT_W,
    parameter int BEATS  = DEF_BEATS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      dir_i,
    input  logic                      chop_i,
    input  logic [BEAT_W*BEATS-1:0]   wr_word_i,
    input  logic [BEAT_W-1:0]         rd_rise_i,
    input  logic [BEAT_W-1:0]         rd_fall_i,
    output logic [BEAT_W-1:0]         dq_rise_o,
    output logic [BEAT_W-1:0]         dq_fall_o,
    output logic                      strobe_en_o,
    output logic [BEAT_W*BEATS-1:0]   rd_word_o,
    output logic                      rd_valid_o
);

    localparam int WORD_W = BEAT_W * BEATS;
    localparam int PAIRS  = BEATS / 2;
    localparam int SLOT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int CNT_W  = $clog2(PAIRS + 1);

    burst_ctx_t        ctx;
    logic              last;
    logic              accept;
    logic [SLOT_W-1:0] slot;

    gb_ctrl #(
        .PAIRS  (PAIRS),
        .SLOT_W (SLOT_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .dir_i    (dir_i),
        .chop_i   (chop_i),
        .ctx_o    (ctx),
        .last_o   (last),
        .accept_o (accept),
        .slot_o   (slot)
    );

    gb_tx #(
        .BEAT_W (BEAT_W),
        .WORD_W (WORD_W)
    ) u_tx (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept && (xfer_dir_e'(dir_i) == XF_WRITE)),
        .word_i (wr_word_i),
        .ctx_i  (ctx),
        .rise_o (dq_rise_o),
        .fall_o (dq_fall_o)
    );

    gb_rx #(
        .BEAT_W (BEAT_W),
        .PAIRS  (PAIRS),
        .SLOT_W (SLOT_W)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .ctx_i   (ctx),
        .last_i  (last),
        .slot_i  (slot),
        .rise_i  (rd_rise_i),
        .fall_i  (rd_fall_i),
        .word_o  (rd_word_o),
        .valid_o (rd_valid_o)
    );

    assign strobe_en_o = ctx.active;

    // R9: beat outputs stay quiet outside strobe cycles
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !strobe_en_o |-> (dq_rise_o == '0 && dq_fall_o == '0));

    // R7: read word valid follows a strobe cycle
    p_valid_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(strobe_en_o));

endmodule

// File: tb/burst_gearbox_tb.sv
`timescale 1ns/1ps
module burst_gearbox_tb;

    localparam int N = 8;
    localparam int W = 64;

    typedef struct packed {
        logic          rd;
        logic          chop;
        logic [W-1:0]  word;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 64'h0807_0605_0403_0201},
        '{1'b0, 1'b1, 64'hDEAD_BEEF_1234_5678},
        '{1'b1, 1'b0, 64'hA5C3_0F96_7E11_B2D4},
        '{1'b1, 1'b1, 64'hFFEE_DDCC_BBAA_9988},
        '{1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 1'b0, 64'h0123_4567_89AB_CDEF}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i, dir_i, chop_i;
    logic [W-1:0] wr_word_i;
    logic [N-1:0] rd_rise_i, rd_fall_i;
    logic [N-1:0] dq_rise_o, dq_fall_o;
    logic         strobe_en_o;
    logic [W-1:0] rd_word_o;
    logic         rd_valid_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_gearbox u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dir_i       (dir_i),
        .chop_i      (chop_i),
        .wr_word_i   (wr_word_i),
        .rd_rise_i   (rd_rise_i),
        .rd_fall_i   (rd_fall_i),
        .dq_rise_o   (dq_rise_o),
        .dq_fall_o   (dq_fall_o),
        .strobe_en_o (strobe_en_o),
        .rd_word_o   (rd_word_o),
        .rd_valid_o  (rd_valid_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected beats for pair k of a word
    function automatic logic [N-1:0] rbeat(input logic [W-1:0] w, input int k);
        return w[2*k*N +: N];
    endfunction
    function automatic logic [N-1:0] fbeat(input logic [W-1:0] w, input int k);
        return w[2*k*N+N +: N];
    endfunction

    task automatic run_burst(input logic rd, input logic chop, input logic [W-1:0] w);
        int pairs;
        logic [W-1:0] expw;
        pairs = chop ? 2 : 4;
        expw  = chop ? {32'h0, w[31:0]} : w;
        @(negedge clk);
        start_i = 1'b1; dir_i = rd; chop_i = chop; wr_word_i = w;
        @(negedge clk);
        start_i = 1'b0; wr_word_i = '0;
        for (int k = 0; k < pairs; k++) begin
            chk("R3 strobe high", W'(strobe_en_o), W'(1));
            if (!rd) begin
                chk(chop ? "R4 rise beat" : "R2 rise beat", W'(dq_rise_o), W'(rbeat(w, k)));
                chk(chop ? "R4 fall beat" : "R2 fall beat", W'(dq_fall_o), W'(fbeat(w, k)));
            end else begin
                chk("R9 quiet on read", W'({dq_fall_o, dq_rise_o}), W'(0));
                rd_rise_i = rbeat(w, k);
                rd_fall_i = fbeat(w, k);
            end
            @(negedge clk);
        end
        rd_rise_i = '0; rd_fall_i = '0;
        chk("R3 strobe low after burst", W'(strobe_en_o), W'(0));
        chk("R9 quiet after burst", W'({dq_fall_o, dq_rise_o}), W'(0));
        if (rd) begin
            chk("R7 valid raised", W'(rd_valid_o), W'(1));
            chk(chop ? "R6 chop read word" : "R5 read word", rd_word_o, expw);
        end else begin
            chk("R7 no valid on write", W'(rd_valid_o), W'(0));
        end
        @(negedge clk);
        chk("R7 valid one cycle", W'(rd_valid_o), W'(0));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] wa, wb;
        rst = 1'b1; start_i = 1'b0; dir_i = 1'b0; chop_i = 1'b0;
        wr_word_i = '0; rd_rise_i = '0; rd_fall_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobe", W'(strobe_en_o), W'(0));
        chk("R1 valid", W'(rd_valid_o), W'(0));
        chk("R1 beats", W'({dq_fall_o, dq_rise_o}), W'(0));
        chk("R1 read word", rd_word_o, W'(0));

        foreach (VECS[i]) run_burst(VECS[i].rd, VECS[i].chop, VECS[i].word);

        // R8 / R10: mid-burst start and input changes are ignored
        wa = 64'h1122_3344_5566_7788;
        @(negedge clk);
        start_i = 1'b1; dir_i = 1'b0; chop_i = 1'b0; wr_word_i = wa;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k == 1) begin
                start_i = 1'b1; dir_i = 1'b1; chop_i = 1'b1; wr_word_i = ~wa;
            end
            if (k == 2) begin
                start_i = 1'b0; wr_word_i = 64'h5A5A_5A5A_5A5A_5A5A;
            end
            chk("R8 strobe held", W'(strobe_en_o), W'(1));
            chk("R10 rise beat unchanged", W'(dq_rise_o), W'(rbeat(wa, k)));
            chk("R10 fall beat unchanged", W'(dq_fall_o), W'(fbeat(wa, k)));
            @(negedge clk);
        end
        dir_i = 1'b0; chop_i = 1'b0;
        chk("R8 no extra burst", W'(strobe_en_o), W'(0));
        chk("R7 no valid after ignored read", W'(rd_valid_o), W'(0));
        @(negedge clk);

        // R8 back-to-back: full read, chopped write launched on its last pair
        wa = 64'hC0DE_CAFE_F00D_BA5E;
        wb = 64'h0000_0000_9A8B_7C6D;
        @(negedge clk);
        start_i = 1'b1; dir_i = 1'b1; chop_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            rd_rise_i = rbeat(wa, k);
            rd_fall_i = fbeat(wa, k);
            if (k == 3) begin
                start_i = 1'b1; dir_i = 1'b0; chop_i = 1'b1; wr_word_i = wb;
            end
            @(negedge clk);
        end
        start_i = 1'b0; rd_rise_i = '0; rd_fall_i = '0;
        chk("R8 gapless strobe", W'(strobe_en_o), W'(1));
        chk("R5 read word alongside write", rd_word_o, wa);
        chk("R7 valid alongside write", W'(rd_valid_o), W'(1));
        chk("R8 first write pair rise", W'(dq_rise_o), W'(rbeat(wb, 0)));
        chk("R8 first write pair fall", W'(dq_fall_o), W'(fbeat(wb, 0)));
        @(negedge clk);
        chk("R4 second pair rise", W'(dq_rise_o), W'(rbeat(wb, 1)));
        chk("R7 valid dropped", W'(rd_valid_o), W'(0));
        @(negedge clk);
        chk("R4 chop ends after two", W'(strobe_en_o), W'(0));

        // R1 reset mid-burst returns to idle
        @(negedge clk);
        start_i = 1'b1; dir_i = 1'b0; chop_i = 1'b0; wr_word_i = wa;
        @(negedge clk);
        start_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 strobe after reset", W'(strobe_en_o), W'(0));
        chk("R1 beats after reset", W'({dq_fall_o, dq_rise_o}), W'(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule